// File: doc/BRIEF.md
# USB Endpoint Halt Status Tracker

This block keeps the stalled state of endpoints 0, 1 and 2 of a USB device and shows it as an 8-bit status word that software can only read. Its inputs come from a control-transfer decoder that has already turned bus traffic into single-cycle events. These events are a SETUP token, an overrun on some endpoint, an undefined control request, and the standard requests that touch the halt feature, each with its target endpoint and a flag that says whether the request was accepted. Firmware can also clear halts with a strobe, and can signal that it has taken over decoding of a request.

Endpoint 0 can be stalled in two unrelated ways. A protocol stall comes from an overrun or an undefined request. It also raises a send-stall flag, and both are dropped by the next SETUP token. A feature halt comes from an accepted SET_FEATURE. It outlives SETUP tokens and goes away only through an explicit clear. Each endpoint holds the two causes in separate flags, and the visible bit is their OR. The bit for endpoint 0 is hidden while the status of endpoint 0 is being queried or changed, or while firmware decodes a request. The bit for endpoint 1 or 2 is hidden while that endpoint is disabled. Interface and configuration changes release every endpoint they name, but never endpoint 0.

Top module: `ep_halt_tracker`

## Requirements
- R1: A synchronous active-high reset sets halt_status to 8'h00 and send_stall to 0.
- R2: Bits 7 to 3 of halt_status always read 0. Bit n (n = 0, 1, 2) is the halt bit of endpoint n.
- R3: An undefined request, or an overrun with ovr_ep = 0, sets halt bit 0 and send_stall on the same edge. The next SETUP token clears both, unless a new endpoint-0 stall event arrives in that same cycle.
- R4: An accepted SET_FEATURE (req_code 3'd1, req_ok 1) with req_ep = 0 sets a halt on endpoint 0 that SETUP tokens do not clear. An accepted CLEAR_FEATURE (req_code 3'd2) to endpoint 0 removes it, and so does a firmware clear.
- R5: Halt bit 0 reads 0 from the edge after any SET_FEATURE, CLEAR_FEATURE or GET_STATUS (req_code 3'd3) to endpoint 0, accepted or not, until the next SETUP token. A fw_dec_ev pulse does the same. send_stall is never hidden.
- R6: For endpoints 1 and 2, an overrun on that endpoint or an accepted SET_FEATURE to it sets its halt bit, and SETUP tokens leave the bit set.
- R7: The halt of endpoint 1 or 2 clears on an accepted CLEAR_FEATURE to it, on a firmware clear, or on an accepted SET_INTERFACE (3'd4) or SET_CONFIGURATION (3'd5) whose req_tgt_mask holds that endpoint. A repeat of the current setting also clears it.
- R8: SET_INTERFACE and SET_CONFIGURATION never change halt bit 0 or send_stall.
- R9: With ep_en[n-1] = 0, halt bit n reads 0. The stored halt comes back into view when the endpoint is enabled again.
- R10: When a set event and a clear event hit the same endpoint in one cycle, the set wins.
- R11: A one-cycle fw_clr_mask bit n clears both halt causes of endpoint n. For endpoint 0 this includes send_stall.
- R12: A SET_FEATURE, CLEAR_FEATURE, SET_INTERFACE or SET_CONFIGURATION with req_ok = 0 neither sets nor clears any halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| setup_tok | input | 1 | SETUP token seen on endpoint 0 |
| undef_req | input | 1 | Undefined control request seen (endpoint 0 stall) |
| ovr_ev | input | 1 | Overrun detected |
| ovr_ep | input | 2 | Endpoint of the overrun |
| req_valid | input | 1 | Standard request event |
| req_code | input | 3 | Request: 1 SET_FEATURE, 2 CLEAR_FEATURE, 3 GET_STATUS, 4 SET_INTERFACE, 5 SET_CONFIGURATION |
| req_ep | input | 2 | Endpoint addressed by the request |
| req_ok | input | 1 | Request accepted (not answered with STALL) |
| req_tgt_mask | input | 2 | Endpoints 2..1 affected by an interface or configuration change |
| fw_clr_mask | input | 3 | Firmware halt-clear strobe, one bit per endpoint |
| fw_dec_ev | input | 1 | Request passed to firmware for decoding |
| ep_en | input | 2 | Enable of endpoints 2..1 in the current setting |
| halt_status | output | 8 | Read-only halt status word |
| send_stall | output | 1 | Endpoint 0 answers with a protocol stall |

## Verification
A hand-written sequence of events drives the two endpoint-0 causes one at a time and then against each other. This shows whether a SETUP token drops only the protocol stall and leaves the feature halt in place. The endpoint-0 bit is also followed through GET_STATUS, the halt requests and firmware decoding, which separates the hidden bit from the stored flag and from send_stall. Endpoints 1 and 2 are released by each clear path in turn: a CLEAR_FEATURE, a firmware strobe, and interface and configuration changes with selective masks. Further patterns cover rejected requests, same-cycle set and clear, and toggling of the enables, which tells a hidden bit apart from a lost one.

// File: rtl/ep_halt_pkg.sv
`timescale 1ns/1ps
// Shared encodings and state types for the endpoint halt tracker.
package ep_halt_pkg;

    // Standard request codes delivered by the control decoder.
    typedef enum logic [2:0] {
        REQ_NONE     = 3'd0,
        REQ_SET_FEAT = 3'd1,
        REQ_CLR_FEAT = 3'd2,
        REQ_GET_STAT = 3'd3,
        REQ_SET_INTF = 3'd4,
        REQ_SET_CONF = 3'd5
    } req_code_e;

    // Two independent halt causes held per endpoint.
    typedef struct packed {
        logic feat;   // halt feature, only an explicit clear removes it
        logic proto;  // protocol stall (overrun / undefined request)
    } slot_state_t;

endpackage

// File: rtl/ep_halt_slot.sv
`timescale 1ns/1ps
// One endpoint's halt flags. A set wins over any clear in the same cycle.
module ep_halt_slot
    import ep_halt_pkg::*;
#(
    parameter bit IS_CTRL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic stall_set,   // protocol stall event for this endpoint
    input  logic feat_set,    // accepted SET_FEATURE to this endpoint
    input  logic clr_req,     // explicit clear of both causes
    input  logic setup_seen,  // SETUP token, only the control endpoint uses it
    output logic feat_o,
    output logic proto_o
);

    slot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_req) begin
            st_d.feat  = 1'b0;
            st_d.proto = 1'b0;
        end
        if (IS_CTRL && setup_seen) begin
            st_d.proto = 1'b0;
        end
        if (feat_set) begin
            st_d.feat = 1'b1;
        end
        if (stall_set) begin
            st_d.proto = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign feat_o  = st_q.feat;
    assign proto_o = st_q.proto;

endmodule

// File: rtl/ep_halt_mask.sv
`timescale 1ns/1ps
// Hides the endpoint-0 halt bit from an arming event until the next SETUP.
module ep_halt_mask (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic setup_seen,
    output logic hidden_o
);

    logic hide_d, hide_q;

    always_comb begin
        hide_d = hide_q;
        if (setup_seen) begin
            hide_d = 1'b0;
        end
        if (arm) begin
            hide_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hide_q <= 1'b0;
        end else begin
            hide_q <= hide_d;
        end
    end

    assign hidden_o = hide_q;

endmodule

// File: rtl/ep_halt_pack.sv
`timescale 1ns/1ps
// Builds the status word from the per-endpoint flags and the view gates.
module ep_halt_pack #(
    parameter int NUM_EP = 3,
    parameter int REG_W  = 8
) (
    input  logic [NUM_EP-1:0] feat_i,
    input  logic [NUM_EP-1:0] proto_i,
    input  logic              ep0_hidden,
    input  logic [NUM_EP-2:0] ep_en,
    output logic [REG_W-1:0]  status_o
);

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (i == 0) begin : g_ctrl
            assign status_o[i] = (feat_i[0] | proto_i[0]) & ~ep0_hidden;
        end else if (i < NUM_EP) begin : g_data
            assign status_o[i] = (feat_i[i] | proto_i[i]) & ep_en[i-1];
        end else begin : g_pad
            assign status_o[i] = 1'b0;
        end
    end

endmodule

// File: rtl/ep_halt_tracker.sv
`timescale 1ns/1ps
// Top: decodes control events into per-endpoint set/clear strobes.
module ep_halt_tracker
    import ep_halt_pkg::*;
#(
    parameter int NUM_EP = 3,
    parameter int REG_W  = 8,
    localparam int EPW   = (NUM_EP > 2) ? $clog2(NUM_EP) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              setup_tok,
    input  logic              undef_req,
    input  logic              ovr_ev,
    input  logic [EPW-1:0]    ovr_ep,
    input  logic              req_valid,
    input  logic [2:0]        req_code,
    input  logic [EPW-1:0]    req_ep,
    input  logic              req_ok,
    input  logic [NUM_EP-2:0] req_tgt_mask,
    input  logic [NUM_EP-1:0] fw_clr_mask,
    input  logic              fw_dec_ev,
    input  logic [NUM_EP-2:0] ep_en,
    output logic [REG_W-1:0]  halt_status,
    output logic              send_stall
);

    req_code_e         code;
    logic              accepted;
    logic              setting_change;
    logic [NUM_EP-1:0] tgt_full;
    logic [NUM_EP-1:0] stall_set;
    logic [NUM_EP-1:0] feat_set;
    logic [NUM_EP-1:0] clr_req;
    logic [NUM_EP-1:0] feat_q;
    logic [NUM_EP-1:0] proto_q;
    logic              hide_arm;
    logic              ep0_hidden;

    assign code           = req_code_e'(req_code);
    assign accepted       = req_valid && req_ok;
    assign setting_change = accepted &&
                            (code == REQ_SET_INTF || code == REQ_SET_CONF);
    // Endpoint 0 never appears in the setting-change target set.
    assign tgt_full       = {req_tgt_mask, 1'b0};

    always_comb begin
        for (int i = 0; i < NUM_EP; i++) begin
            stall_set[i] = (ovr_ev && (ovr_ep == EPW'(i))) ||
                           ((i == 0) && undef_req);
            feat_set[i]  = accepted && (req_ep == EPW'(i)) &&
                           (code == REQ_SET_FEAT);
            clr_req[i]   = (accepted && (req_ep == EPW'(i)) &&
                            (code == REQ_CLR_FEAT)) ||
                           fw_clr_mask[i] ||
                           (setting_change && tgt_full[i]);
        end
    end

    // Halt-related requests to endpoint 0 hide its bit whether or not accepted.
    assign hide_arm = fw_dec_ev ||
                      (req_valid && (req_ep == '0) &&
                       (code == REQ_SET_FEAT || code == REQ_CLR_FEAT ||
                        code == REQ_GET_STAT));

    for (genvar e = 0; e < NUM_EP; e++) begin : g_slot
        ep_halt_slot #(
            .IS_CTRL (e == 0)
        ) u_slot (
            .clk        (clk),
            .rst        (rst),
            .stall_set  (stall_set[e]),
            .feat_set   (feat_set[e]),
            .clr_req    (clr_req[e]),
            .setup_seen (setup_tok),
            .feat_o     (feat_q[e]),
            .proto_o    (proto_q[e])
        );
    end

    ep_halt_mask u_mask (
        .clk        (clk),
        .rst        (rst),
        .arm        (hide_arm),
        .setup_seen (setup_tok),
        .hidden_o   (ep0_hidden)
    );

    ep_halt_pack #(
        .NUM_EP (NUM_EP),
        .REG_W  (REG_W)
    ) u_pack (
        .feat_i     (feat_q),
        .proto_i    (proto_q),
        .ep0_hidden (ep0_hidden),
        .ep_en      (ep_en),
        .status_o   (halt_status)
    );

    assign send_stall = proto_q[0];

endmodule

// File: rtl/ep_halt_tracker_chk.sv
`timescale 1ns/1ps
// Port-level checks bound onto the tracker.
module ep_halt_tracker_chk #(
    parameter int NUM_EP = 3,
    parameter int REG_W  = 8,
    localparam int EPW   = (NUM_EP > 2) ? $clog2(NUM_EP) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              setup_tok,
    input logic              undef_req,
    input logic              ovr_ev,
    input logic [EPW-1:0]    ovr_ep,
    input logic              req_valid,
    input logic [2:0]        req_code,
    input logic              req_ok,
    input logic [NUM_EP-1:0] fw_clr_mask,
    input logic              fw_dec_ev,
    input logic [NUM_EP-2:0] ep_en,
    input logic [REG_W-1:0]  halt_status,
    input logic              send_stall
);

    logic ep0_stall_ev;
    assign ep0_stall_ev = undef_req || (ovr_ev && (ovr_ep == '0));

    a_r1_reset_clean: assert property (@(posedge clk)
        rst |=> (halt_status == '0 && !send_stall));

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        halt_status[REG_W-1:NUM_EP] == '0);

    a_r3_stall_raises: assert property (@(posedge clk) disable iff (rst)
        undef_req |=> send_stall);

    a_r3_setup_drops: assert property (@(posedge clk) disable iff (rst)
        (setup_tok && !ep0_stall_ev) |=> !send_stall);

    a_r5_fw_decode_hides: assert property (@(posedge clk) disable iff (rst)
        fw_dec_ev |=> !halt_status[0]);

    a_r8_change_spares_ep0: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ok && (req_code == 3'd4 || req_code == 3'd5) &&
         !setup_tok && !ep0_stall_ev && !fw_clr_mask[0] && !fw_dec_ev)
        |=> ($stable(halt_status[0]) && $stable(send_stall)));

    a_r10_overrun_wins_ep1: assert property (@(posedge clk) disable iff (rst)
        (ovr_ev && ovr_ep == EPW'(1)) |=> (halt_status[1] || !ep_en[0]));

    a_r11_fw_clear_ep0: assert property (@(posedge clk) disable iff (rst)
        (fw_clr_mask[0] && !ep0_stall_ev) |=> !send_stall);

endmodule

bind ep_halt_tracker ep_halt_tracker_chk #(
    .NUM_EP (NUM_EP),
    .REG_W  (REG_W)
) u_chk (.*);

// File: tb/tb_ep_halt_tracker.sv
`timescale 1ns/1ps
module tb_ep_halt_tracker;

    logic       clk = 1'b0;
    logic       rst;
    logic       setup_tok, undef_req, ovr_ev, req_valid, req_ok, fw_dec_ev;
    logic [1:0] ovr_ep, req_ep, req_tgt_mask, ep_en;
    logic [2:0] req_code, fw_clr_mask;
    logic [7:0] halt_status;
    logic       send_stall;

    // staged stimulus for the next cycle
    logic       s_setup, s_undef, s_ovr, s_req, s_ok, s_dec;
    logic [1:0] s_ovr_ep, s_req_ep, s_tgt, s_en;
    logic [2:0] s_code, s_fwclr;

    logic [8:0] exp_q[$];
    string      tag_q[$];
    int         checks = 0;
    int         bad = 0;
    bit         finished = 1'b0;

    always #5 clk = ~clk;

    ep_halt_tracker dut (
        .clk(clk), .rst(rst), .setup_tok(setup_tok), .undef_req(undef_req),
        .ovr_ev(ovr_ev), .ovr_ep(ovr_ep), .req_valid(req_valid),
        .req_code(req_code), .req_ep(req_ep), .req_ok(req_ok),
        .req_tgt_mask(req_tgt_mask), .fw_clr_mask(fw_clr_mask),
        .fw_dec_ev(fw_dec_ev), .ep_en(ep_en), .halt_status(halt_status),
        .send_stall(send_stall)
    );

    task automatic clear_stage();
        s_setup = 0; s_undef = 0; s_ovr = 0; s_ovr_ep = 0;
        s_req = 0; s_code = 0; s_req_ep = 0; s_ok = 0; s_tgt = 0;
        s_fwclr = 0; s_dec = 0;
    endtask

    task automatic stage_req(input logic [2:0] c, input logic [1:0] e,
                             input logic ok, input logic [1:0] t);
        s_req = 1; s_code = c; s_req_ep = e; s_ok = ok; s_tgt = t;
    endtask

    // Driver: apply staged stimulus for one cycle, queue the expected result.
    task automatic go(input logic [7:0] es, input logic ess, input string tag);
        @(posedge clk); #3;
        setup_tok = s_setup; undef_req = s_undef; ovr_ev = s_ovr;
        ovr_ep = s_ovr_ep; req_valid = s_req; req_code = s_code;
        req_ep = s_req_ep; req_ok = s_ok; req_tgt_mask = s_tgt;
        fw_clr_mask = s_fwclr; fw_dec_ev = s_dec; ep_en = s_en;
        clear_stage();
        exp_q.push_back({ess, es});
        tag_q.push_back(tag);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", checks, bad);
    endtask

    // Monitor: one edge after a stimulus cycle the result must be visible.
    initial begin
        forever begin
            @(posedge clk); #1;
            if (exp_q.size() > 0) begin
                logic [8:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if ({send_stall, halt_status} !== e) begin
                    bad++;
                    $display("FAIL %s actual stall=%0b status=%h expected stall=%0b status=%h",
                             t, send_stall, halt_status, e[8], e[7:0]);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++;
            checks++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        clear_stage();
        s_en = 2'b11;
        rst = 1; setup_tok = 0; undef_req = 0; ovr_ev = 0; ovr_ep = 0;
        req_valid = 0; req_code = 0; req_ep = 0; req_ok = 0;
        req_tgt_mask = 0; fw_clr_mask = 0; fw_dec_ev = 0; ep_en = 2'b11;
        repeat (3) @(posedge clk);
        #3 rst = 0;
        #1;
        checks++;
        if (halt_status !== 8'h00 || send_stall !== 1'b0) begin
            bad++;
            $display("FAIL R1 R2 reset actual stall=%0b status=%h expected stall=0 status=00",
                     send_stall, halt_status);
        end

        // R3: protocol stall on endpoint 0 and its release by SETUP
        s_undef = 1;                 go(8'h01, 1, "R3 undefined request");
                                     go(8'h01, 1, "R3 stall holds");
        s_setup = 1;                 go(8'h00, 0, "R3 setup releases");
        s_ovr = 1; s_ovr_ep = 0;     go(8'h01, 1, "R3 overrun ep0");
        s_setup = 1; s_undef = 1;    go(8'h01, 1, "R10 stall beats setup");
        s_setup = 1;                 go(8'h00, 0, "R3 setup releases again");

        // R4 / R5: feature halt on endpoint 0
        stage_req(3'd1, 2'd0, 1, 0); go(8'h00, 0, "R5 set_feature ep0 hidden");
        s_setup = 1;                 go(8'h01, 0, "R4 halt visible after setup");
        s_setup = 1;                 go(8'h01, 0, "R4 setup does not clear feature");
        stage_req(3'd4, 2'd0, 1, 2'b11); go(8'h01, 0, "R8 set_interface spares ep0");
        stage_req(3'd5, 2'd0, 1, 2'b11); go(8'h01, 0, "R8 set_configuration spares ep0");
        stage_req(3'd2, 2'd0, 1, 0); go(8'h00, 0, "R4 clear_feature ep0");
        s_setup = 1;                 go(8'h00, 0, "R4 stays clear after setup");
        stage_req(3'd1, 2'd0, 1, 0); go(8'h00, 0, "R5 set_feature ep0 hidden");
        s_setup = 1;                 go(8'h01, 0, "R4 halt back in view");
        s_fwclr = 3'b001;            go(8'h00, 0, "R11 firmware clears ep0 feature");

        // R6 / R9 / R12 / R7: data endpoints
        s_ovr = 1; s_ovr_ep = 1;     go(8'h02, 0, "R6 overrun ep1");
        s_setup = 1;                 go(8'h02, 0, "R6 setup leaves ep1");
        stage_req(3'd1, 2'd2, 1, 0); go(8'h06, 0, "R6 set_feature ep2");
        s_en = 2'b01;                go(8'h02, 0, "R9 ep2 disabled reads 0");
        s_en = 2'b11;                go(8'h06, 0, "R9 ep2 re-enabled");
        stage_req(3'd4, 2'd0, 0, 2'b11); go(8'h06, 0, "R12 rejected set_interface");
        stage_req(3'd2, 2'd2, 0, 0); go(8'h06, 0, "R12 rejected clear_feature");
        stage_req(3'd4, 2'd0, 1, 2'b10); go(8'h02, 0, "R7 set_interface clears ep2 only");
        stage_req(3'd5, 2'd0, 1, 2'b01); go(8'h00, 0, "R7 set_configuration clears ep1");
        stage_req(3'd1, 2'd1, 1, 0); go(8'h02, 0, "R6 set_feature ep1");
        stage_req(3'd2, 2'd1, 1, 0); go(8'h00, 0, "R7 clear_feature ep1");
        s_ovr = 1; s_ovr_ep = 2;     go(8'h04, 0, "R6 overrun ep2");
        s_fwclr = 3'b100;            go(8'h00, 0, "R11 firmware clears ep2");
        stage_req(3'd1, 2'd1, 1, 0); s_fwclr = 3'b010;
                                     go(8'h02, 0, "R10 set beats firmware clear");
        stage_req(3'd5, 2'd0, 1, 2'b11); go(8'h00, 0, "R7 same configuration still clears");
        stage_req(3'd1, 2'd2, 0, 0); go(8'h00, 0, "R12 rejected set_feature ep2");

        // R11 / R5: endpoint-0 protocol stall cleared and hidden
        s_undef = 1;                 go(8'h01, 1, "R3 undefined request again");
        s_fwclr = 3'b001;            go(8'h00, 0, "R11 firmware clears send_stall");
        s_undef = 1;                 go(8'h01, 1, "R3 stall for masking");
        stage_req(3'd3, 2'd0, 1, 0); go(8'h00, 1, "R5 get_status hides bit not flag");
        s_setup = 1;                 go(8'h00, 0, "R5 setup ends hiding");
        stage_req(3'd1, 2'd0, 1, 0); go(8'h00, 0, "R5 hidden by set_feature");
        s_setup = 1;                 go(8'h01, 0, "R4 ep0 halt shown");
        s_dec = 1;                   go(8'h00, 0, "R5 firmware decode hides");
                                     go(8'h00, 0, "R5 hidden until setup");
        s_setup = 1;                 go(8'h01, 0, "R5 visible after setup");
        stage_req(3'd2, 2'd0, 0, 0); go(8'h00, 0, "R12 rejected clear still hides");
        s_setup = 1;                 go(8'h01, 0, "R12 rejected clear kept halt");
        stage_req(3'd2, 2'd0, 1, 0); go(8'h00, 0, "R4 clear_feature ep0 again");
        s_setup = 1;                 go(8'h00, 0, "R4 cleared for good");

        repeat (3) @(posedge clk);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule